// File: doc/BRIEF.md
# I2C Slave Word Transmitter

This block is the transmit half of an I2C slave. It watches the bus for a START, shifts in the address byte, and acknowledges it only when the 7-bit address equals its own and the direction bit asks for a read. It then sends data words of one, two or three bytes to the external master, most significant bit first, and checks the master's acknowledge after every byte. A host writes words into a holding register. The holding register is copied into the output shift register only when a whole word has left the bus.

If the holding register is still empty when a new word is due, the block does one of two things, set by a configuration input. It can flag an underrun and send the previous word again. Or it can hold SCL low until the host supplies a word. A host-request output can be enabled so that a second device gets a hardware handshake each time a word is taken from the holding register. An activity output is high for the length of a transmit session, so that a neighbouring receive path can block its shift-register-to-FIFO transfers.

Top module: `i2c_word_tx`

## Requirements
- R1: A session starts, and the block pulls SDA low on the ninth clock of the address byte, only when the first seven received bits equal `ownAddr` and the eighth bit is 1. On any other address byte, including its own address with the eighth bit 0, SDA is never driven and `txActive` stays 0.
- R2: Data bits leave the block most significant bit first. The block changes its SDA drive only while the synchronized SCL is low.
- R3: When the master leaves SDA high on the ninth clock after a data byte (NACK), the block releases SDA and ends the session (`txActive` falls to 0).
- R4: `wordMode` sets the bytes per word: 00 gives 1, 01 gives 2, 10 and 11 give 3. A word of N bytes occupies the low 8·N bits of `hostWrData`, and its top byte is sent first. The holding register is transferred only after the ACK clock of the address byte or of a word's last byte, never in the middle of a word.
- R5: `txEmpty` is 1 after reset. It goes to 0 on a host write and back to 1 when the holding register is transferred to the shift register.
- R6: With `stretchEn` = 0, when a word is due and the holding register is empty, `underrun` is set and the last word sent is sent again. A host write clears `underrun`.
- R7: With `stretchEn` = 1, when a word is due and the holding register is empty, `sclLowEn` holds SCL low until the host writes. The new word is then sent and `underrun` stays 0.
- R8: With `reqSel` = 10, `hostReq` rises when the holding register is transferred, and falls on the first SCL rising edge of the word that was transferred. For any other `reqSel` value, `hostReq` stays 0.
- R9: A START or STOP condition aborts any session in progress: `txActive` drops and SDA is released.
- R10: After reset, `sdaLowEn`, `sclLowEn`, `txActive`, `underrun` and `hostReq` are 0 and `txEmpty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL level sensed on the bus |
| sdaIn | input | 1 | SDA level sensed on the bus |
| sclLowEn | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaLowEn | output | 1 | 1 pulls SDA low (open-drain data) |
| ownAddr | input | ADDR_W | Own 7-bit slave address |
| wordMode | input | 2 | Bytes per word: 00=1, 01=2, 10/11=3 |
| stretchEn | input | 1 | 1 = stretch SCL when data is missing, 0 = underrun and resend |
| reqSel | input | 2 | Host-request selection; 10 enables transmit requests |
| hostWrEn | input | 1 | Host write strobe for the holding register |
| hostWrData | input | 8*MAX_BYTES | Word written by the host, right-aligned |
| txEmpty | output | 1 | Holding register is empty |
| underrun | output | 1 | A word was resent because no data was ready |
| hostReq | output | 1 | Hardware request for the next word |
| txActive | output | 1 | Transmit session in progress (receive transfers inhibited) |

## Verification
The bench builds the block with its defaults: a 7-bit address, words of up to three bytes and two-flop synchronizers. At that size all four word-length encodings can be reached, including 11 falling back to three bytes. Two-byte words expose the rule that the holding register is not refilled mid-word. The two-stage synchronizers set the latency that the bench's master, with eight-cycle SCL phases, has to absorb between a clock edge and a data change. Both empty-buffer policies and both settings of the request selection are run in sessions that follow one another, so leftover state from one session reaches the next.

// File: rtl/i2c_wtx_pkg.sv
package i2c_wtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_TX_BIT,
    ST_TX_ACK,
    ST_STRETCH
  } txState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWord;   // word boundary: refill the shift register
    logic shiftBit;   // advance to the next bit
    logic firstPulse; // first SCL rise of a freshly loaded word
  } txStrobe_t;

  // Bytes per word for a two-bit mode code, clamped to the datapath size
  function automatic int unsigned bytesPerWord(input logic [1:0] mode,
                                               input int unsigned maxBytes);
    int unsigned n;
    case (mode)
      2'b00:   n = 1;
      2'b01:   n = 2;
      default: n = 3;
    endcase
    if (n > maxBytes) n = maxBytes;
    return n;
  endfunction

endpackage

// File: rtl/i2c_wtx_sync.sv
module i2c_wtx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '1;
        else       chain <= din;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_wtx_ctrl.sv
module i2c_wtx_ctrl
  import i2c_wtx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int MAX_BYTES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [1:0]        wordMode,
  input  logic              stretchEn,
  input  logic              holdFull,
  input  logic              txBit,
  output txStrobe_t         strobe,
  output logic              sdaLowEn,
  output logic              sclLowEn,
  output logic              txActive
);
  localparam int BYTE_CW = $clog2(MAX_BYTES + 1);
  localparam int ABYTE_W = ADDR_W + 1;
  localparam int BIT_CW  = $clog2(ABYTE_W + 1);

  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startDet, stopDet, busEvent;
  txState_t st;
  logic [BIT_CW-1:0]  bitCnt;
  logic [BYTE_CW-1:0] byteIdx, nBytes;
  logic [ABYTE_W-1:0] addrSr;
  logic ackLow, boundary, lastByte, addrHit;

  i2c_wtx_sync #(.STAGES(SYNC_STAGES)) uSclSync (.clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  i2c_wtx_sync #(.STAGES(SYNC_STAGES)) uSdaSync (.clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign busEvent = startDet | stopDet;

  assign nBytes   = BYTE_CW'(bytesPerWord(wordMode, MAX_BYTES));
  assign lastByte = (byteIdx == nBytes - 1'b1);
  assign addrHit  = (addrSr[ABYTE_W-1:1] == ownAddr) && addrSr[0];

  always_comb begin
    boundary = 1'b0;
    if (!busEvent) begin
      if (st == ST_ADDR_ACK && sclFall) boundary = 1'b1;
      if (st == ST_TX_ACK && sclFall && ackLow && lastByte) boundary = 1'b1;
    end
    strobe.loadWord   = (boundary && (holdFull || !stretchEn)) ||
                        (st == ST_STRETCH && holdFull);
    strobe.shiftBit   = (st == ST_TX_BIT) && sclFall;
    strobe.firstPulse = (st == ST_TX_BIT) && sclRise &&
                        (bitCnt == '0) && (byteIdx == '0);
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      st      <= ST_IDLE;
      bitCnt  <= '0;
      byteIdx <= '0;
      addrSr  <= '0;
      ackLow  <= 1'b0;
    end else if (busEvent) begin
      st      <= startDet ? ST_ADDR : ST_IDLE;
      bitCnt  <= '0;
      byteIdx <= '0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (sclRise) begin
            addrSr <= {addrSr[ABYTE_W-2:0], sdaS};
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && bitCnt == BIT_CW'(ABYTE_W)) begin
            st     <= addrHit ? ST_ADDR_ACK : ST_IDLE;
            bitCnt <= '0;
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            st      <= strobe.loadWord ? ST_TX_BIT : ST_STRETCH;
            bitCnt  <= '0;
            byteIdx <= '0;
          end
        end
        ST_STRETCH: begin
          if (holdFull) st <= ST_TX_BIT;
        end
        ST_TX_BIT: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == BIT_CW'(8)) begin
            st     <= ST_TX_ACK;
            bitCnt <= '0;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) ackLow <= ~sdaS;
          else if (sclFall) begin
            if (!ackLow) st <= ST_IDLE;
            else if (lastByte) begin
              st      <= strobe.loadWord ? ST_TX_BIT : ST_STRETCH;
              byteIdx <= '0;
            end else begin
              st      <= ST_TX_BIT;
              byteIdx <= byteIdx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end

  assign sdaLowEn = (st == ST_ADDR_ACK) || (st == ST_TX_BIT && !txBit);
  assign sclLowEn = (st == ST_STRETCH);
  assign txActive = (st == ST_ADDR_ACK) || (st == ST_TX_BIT) ||
                    (st == ST_TX_ACK) || (st == ST_STRETCH);

  // R2: the SDA drive never moves while SCL stays high
  p_sda_steady_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclP && !$past(busEvent)) |-> $stable(sdaLowEn));

  // R1: a session opens only after a matching read address
  p_addr_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> $past(addrHit));

  // R3: a NACK ends the session and frees SDA
  p_nack_ends_r3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_TX_ACK && sclFall && !ackLow && !busEvent) |=> (!txActive && !sdaLowEn));

  // R7: stretching starts only when enabled and no word is waiting
  p_stretch_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclLowEn) |-> ($past(stretchEn) && !$past(holdFull)));

  // R9: a STOP ends any session
  p_stop_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !txActive);
endmodule

// File: rtl/i2c_wtx_datapath.sv
module i2c_wtx_datapath
  import i2c_wtx_pkg::*;
#(
  parameter int MAX_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  txStrobe_t              strobe,
  input  logic [1:0]             wordMode,
  input  logic [1:0]             reqSel,
  input  logic                   hostWrEn,
  input  logic [8*MAX_BYTES-1:0] hostWrData,
  output logic                   holdFull,
  output logic                   txBit,
  output logic                   txEmpty,
  output logic                   underrun,
  output logic                   hostReq
);
  localparam int          DATA_W  = 8 * MAX_BYTES;
  localparam logic [1:0]  REQ_TX  = 2'b10;

  logic [DATA_W-1:0] holdReg, shiftReg, lastWord, loadSrc;
  logic reqFlag;
  int unsigned shiftAmt;

  assign loadSrc  = holdFull ? holdReg : lastWord;
  assign shiftAmt = 8 * (MAX_BYTES - bytesPerWord(wordMode, MAX_BYTES));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shiftReg <= '0;
      lastWord <= '0;
      underrun <= 1'b0;
      reqFlag  <= 1'b0;
    end else begin
      if (hostWrEn) begin
        holdReg  <= hostWrData;
        holdFull <= 1'b1;
      end else if (strobe.loadWord && holdFull) begin
        holdFull <= 1'b0;
      end

      if (strobe.loadWord) begin
        shiftReg <= loadSrc << shiftAmt;
        lastWord <= loadSrc;
      end else if (strobe.shiftBit) begin
        shiftReg <= shiftReg << 1;
      end

      if (hostWrEn)                              underrun <= 1'b0;
      else if (strobe.loadWord && !holdFull)     underrun <= 1'b1;

      if (strobe.loadWord && holdFull)           reqFlag <= 1'b1;
      else if (strobe.firstPulse)                reqFlag <= 1'b0;
    end

  assign txBit   = shiftReg[DATA_W-1];
  assign txEmpty = ~holdFull;
  assign hostReq = reqFlag && (reqSel == REQ_TX);

  // R5: a transfer empties the holding register
  p_empty_on_xfer_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWord && holdFull && !hostWrEn) |=> txEmpty);

  // R6: a word due with nothing held raises underrun
  p_underrun_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWord && !holdFull && !hostWrEn) |=> underrun);

  // R6: a host write clears underrun
  p_underrun_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |=> !underrun);

  // R8: a transfer with transmit requests enabled raises the request
  p_req_on_xfer_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadWord && holdFull && reqSel == REQ_TX && $stable(reqSel)) |=> hostReq);
endmodule

// File: rtl/i2c_word_tx.sv
module i2c_word_tx
  import i2c_wtx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int MAX_BYTES   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sclLowEn,
  output logic                   sdaLowEn,
  input  logic [ADDR_W-1:0]      ownAddr,
  input  logic [1:0]             wordMode,
  input  logic                   stretchEn,
  input  logic [1:0]             reqSel,
  input  logic                   hostWrEn,
  input  logic [8*MAX_BYTES-1:0] hostWrData,
  output logic                   txEmpty,
  output logic                   underrun,
  output logic                   hostReq,
  output logic                   txActive
);
  txStrobe_t strobe;
  logic holdFull, txBit;

  i2c_wtx_ctrl #(
    .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .wordMode(wordMode), .stretchEn(stretchEn),
    .holdFull(holdFull), .txBit(txBit), .strobe(strobe),
    .sdaLowEn(sdaLowEn), .sclLowEn(sclLowEn), .txActive(txActive)
  );

  i2c_wtx_datapath #(.MAX_BYTES(MAX_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordMode(wordMode),
    .reqSel(reqSel), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .holdFull(holdFull), .txBit(txBit), .txEmpty(txEmpty),
    .underrun(underrun), .hostReq(hostReq)
  );
endmodule

// File: tb/i2c_word_tx_test.sv
module i2c_word_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int WATCHDOG   = 150000;
  localparam logic [6:0] OWN = 7'h2C;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sclLine, sdaLine, sclLowEn, sdaLowEn;
  logic [1:0] wordMode = 2'b00, reqSel = 2'b00;
  logic stretchEn = 1'b0, hostWrEn = 1'b0;
  logic [23:0] hostWrData = '0;
  logic txEmpty, underrun, hostReq, txActive;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclLine = sclM & ~sclLowEn;
  assign sdaLine = sdaM & ~sdaLowEn;

  i2c_word_tx uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclLowEn(sclLowEn), .sdaLowEn(sdaLowEn), .ownAddr(OWN),
    .wordMode(wordMode), .stretchEn(stretchEn), .reqSel(reqSel),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .txEmpty(txEmpty),
    .underrun(underrun), .hostReq(hostReq), .txActive(txActive)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [23:0] w);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = w;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; waitCyc(H);
    sdaM = 1'b0; waitCyc(H);
    sclM = 1'b0; waitCyc(H);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitCyc(H);
    sclM = 1'b1; waitCyc(H);
    sdaM = 1'b1; waitCyc(H);
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaM = b; waitCyc(H);
    sclM = 1'b1;
    do @(negedge clk); while (!sclLine);
    waitCyc(H/2); s = sdaLine; waitCyc(H/2);
    sclM = 1'b0; waitCyc(4);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic readByte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      d[i] = s;
    end
    clockBit(nack, s);
  endtask

  task automatic testReset();
    checkEq("R10 sdaLowEn", sdaLowEn, 0);
    checkEq("R10 sclLowEn", sclLowEn, 0);
    checkEq("R10 txActive", txActive, 0);
    checkEq("R10 underrun", underrun, 0);
    checkEq("R10 hostReq", hostReq, 0);
    checkEq("R5 txEmpty at reset", txEmpty, 1);
  endtask

  task automatic testAddrFilter();
    logic ok;
    startCond();
    writeByte({7'h2D, 1'b1}, ok);
    checkEq("R1 foreign address not acked", ok, 0);
    checkEq("R1 foreign address no session", txActive, 0);
    stopCond();
    startCond();
    writeByte({OWN, 1'b0}, ok);
    checkEq("R1 own write address not acked", ok, 0);
    checkEq("R1 own write address no session", txActive, 0);
    stopCond();
  endtask

  task automatic testSingleByteWords();
    logic ok; logic [7:0] d;
    wordMode = 2'b00; reqSel = 2'b10; stretchEn = 1'b0;
    hostWrite(24'h0000A5);
    checkEq("R5 txEmpty after write", txEmpty, 0);
    startCond();
    writeByte({OWN, 1'b1}, ok);
    checkEq("R1 own read address acked", ok, 1);
    checkEq("R9 txActive in session", txActive, 1);
    checkEq("R5 txEmpty after transfer", txEmpty, 1);
    checkEq("R8 hostReq on transfer", hostReq, 1);
    hostWrite(24'h00003C);
    readByte(1'b0, d);
    checkEq("R2 first byte msb first", d, 8'hA5);
    readByte(1'b1, d);
    checkEq("R2 second byte", d, 8'h3C);
    checkEq("R8 hostReq cleared by first pulse", hostReq, 0);
    checkEq("R3 nack ends session", txActive, 0);
    checkEq("R3 nack releases sda", sdaLowEn, 0);
    stopCond();
  endtask

  task automatic testTwoByteWords();
    logic ok; logic [7:0] d;
    wordMode = 2'b01; reqSel = 2'b01;
    hostWrite(24'h001234);
    startCond();
    writeByte({OWN, 1'b1}, ok);
    checkEq("R1 ack 16-bit session", ok, 1);
    checkEq("R8 hostReq masked by reqSel", hostReq, 0);
    hostWrite(24'h005678);
    readByte(1'b0, d);
    checkEq("R4 word byte 1", d, 8'h12);
    checkEq("R4 no refill mid-word", txEmpty, 0);
    readByte(1'b0, d);
    checkEq("R4 word byte 2", d, 8'h34);
    checkEq("R4 refill at word end", txEmpty, 1);
    readByte(1'b0, d);
    checkEq("R4 next word byte 1", d, 8'h56);
    readByte(1'b1, d);
    checkEq("R4 next word byte 2", d, 8'h78);
    checkEq("R8 hostReq still masked", hostReq, 0);
    stopCond();
  endtask

  task automatic testWideWords();
    logic ok; logic [7:0] d;
    wordMode = 2'b11;
    hostWrite(24'hABCDEF);
    startCond();
    writeByte({OWN, 1'b1}, ok);
    readByte(1'b0, d);
    checkEq("R4 mode 11 byte 1", d, 8'hAB);
    readByte(1'b0, d);
    checkEq("R4 mode 11 byte 2", d, 8'hCD);
    readByte(1'b1, d);
    checkEq("R4 mode 11 byte 3", d, 8'hEF);
    stopCond();
  endtask

  task automatic testUnderrun();
    logic ok; logic [7:0] d;
    wordMode = 2'b00; stretchEn = 1'b0;
    hostWrite(24'h00005A);
    startCond();
    writeByte({OWN, 1'b1}, ok);
    readByte(1'b1, d);
    checkEq("R2 byte before underrun", d, 8'h5A);
    stopCond();
    startCond();
    writeByte({OWN, 1'b1}, ok);
    checkEq("R6 underrun flagged", underrun, 1);
    readByte(1'b1, d);
    checkEq("R6 previous word resent", d, 8'h5A);
    stopCond();
    hostWrite(24'h0000F0);
    checkEq("R6 write clears underrun", underrun, 0);
  endtask

  task automatic testAbort();
    logic ok;
    startCond();
    writeByte({OWN, 1'b1}, ok);
    checkEq("R9 session open before stop", txActive, 1);
    stopCond();
    checkEq("R9 stop aborts session", txActive, 0);
    checkEq("R9 sda free after stop", sdaLowEn, 0);
  endtask

  task automatic testStretch();
    logic ok; logic [7:0] d;
    stretchEn = 1'b1; wordMode = 2'b00;
    checkEq("R7 holding register empty", txEmpty, 1);
    startCond();
    writeByte({OWN, 1'b1}, ok);
    fork
      readByte(1'b1, d);
      begin
        waitCyc(40);
        checkEq("R7 scl held low while empty", sclLowEn, 1);
        checkEq("R7 no underrun when stretching", underrun, 0);
        hostWrite(24'h0000C3);
      end
    join
    checkEq("R7 word sent after stretch", d, 8'hC3);
    checkEq("R7 scl released", sclLowEn, 0);
    checkEq("R7 underrun stays clear", underrun, 0);
    stopCond();
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(3);
    testReset();
    testAddrFilter();
    testSingleByteWords();
    testTwoByteWords();
    testWideWords();
    testUnderrun();
    testAbort();
    testStretch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule